// File: doc/BRIEF.md
# Audio Bit-Clock and Frame-Sync Generator

This block turns a kernel clock into the three timing signals of a serial audio link: an optional master clock, the bit clock and the word-select (frame) signal. A programmable prescaler divides the kernel clock by 2·DIV + ODD. When the master clock is enabled, the prescaler output is the master clock. The bit clock is then derived from it, so that the master clock runs at 256 times the frame rate in standard mode or 128 times in DSP mode. When the master clock is disabled, the prescaler output is itself the bit clock.

Divider and framing settings are captured only while the block is disabled. Enabling the block restarts every counter in a fixed phase. Disabling it parks all clock outputs low. A DIV/ODD pair that cannot be built is flagged, and the block refuses to start with it. The serializer next to this block uses a one-cycle strobe that marks every falling bit-clock edge.

Top module: `audio_clkgen`

## Requirements
- R1: With master clock off and DIV ≥ 1, bclk_o repeats every 2·DIV+ODD kernel cycles. It is high for DIV+ODD cycles and then low for DIV cycles, and it is high in the first running cycle.
- R2: Every DIV value from 1 to 255 is honoured, including the largest ratio of 511.
- R3: div_i = 1 with odd_i = 1 is illegal. One cycle after such a setting is sampled while disabled, err_o is 1, and all outputs stay low even if en_i is 1. A legal setting sampled while disabled clears err_o.
- R4: DIV = 0 gives a ratio of one. The prescaled clock is the kernel clock itself: bclk_o is high while clk_i is high and low while clk_i is low.
- R5: With mck_en_i = 1, mclk_o has the R1 shape. bclk_o is high for half of M master-clock periods and low for the other half, with both starting at enable. M is 8 when wide_i = 0 and 4 when wide_i = 1, which gives 256·fs (dsp_i = 0) or 128·fs (dsp_i = 1).
- R6: With mck_en_i = 0, mclk_o stays low. A frame spans F bit clocks, where F = 32 (dsp_i = 0, wide_i = 0), 64 (dsp_i = 0, wide_i = 1), 16 (dsp_i = 1, wide_i = 0) or 32 (dsp_i = 1, wide_i = 1).
- R7: Out of reset, and from the second cycle after en_i drops, mclk_o, bclk_o, ws_o and bclk_stb_o are all 0.
- R8: ws_o is 0 at enable. It toggles together with the bclk_o fall that ends every F/2 bit periods.
- R9: bclk_stb_o is a single-cycle pulse in the first kernel cycle in which bclk_o is low after each of its falls, and it is never asserted at any other time.
- R10: Changes on div_i, odd_i, mck_en_i, dsp_i and wide_i while running have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| div_i | input | DIV_W | Prescaler half-ratio DIV |
| odd_i | input | 1 | Adds one to the ratio |
| mck_en_i | input | 1 | Master clock output enable |
| dsp_i | input | 1 | 1 = DSP framing (short frame, 128·fs master clock) |
| wide_i | input | 1 | 1 = 32-bit slots, 0 = 16-bit slots |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select |
| err_o | output | 1 | Illegal divider setting sampled |
| bclk_stb_o | output | 1 | Falling bit-clock edge strobe |

## Verification
The embedded properties check several rules on every cycle. The prescaler count stays inside its ratio. The prescaled clock rises only after a wrap. A bit-clock fall from the master-clock sub-divider is always preceded by a bit-end event, and word select changes only in a strobe cycle. An error flag never coexists with a running block, and captured settings stay frozen while running. The exact periods, duty split, frame length for each framing mode and the pass-through level are visible only by comparing whole runs against closed-form waveforms in the bench. The same holds for showing that scrambled inputs in mid-run are ignored.

// File: rtl/acg_pkg.sv
package acg_pkg;
  localparam int unsigned DIV_W_DEF      = 8;
  localparam int unsigned MCK_FS_STD_DEF = 256;
  localparam int unsigned MCK_FS_DSP_DEF = 128;
  localparam int unsigned FRAME_STD_DEF  = 32;
  localparam int unsigned FRAME_DSP_DEF  = 16;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/acg_prescaler.sv
module acg_prescaler #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             bypass_i,
  input  logic [DIV_W:0]   ratio_i,
  input  logic [DIV_W:0]   high_i,
  output logic             lvl_o,
  output logic             wrap_o,
  output logic             fall_o
);
  logic [DIV_W:0] cnt_q, cnt_nxt;
  logic           lvl_q;

  assign wrap_o  = run_i & (bypass_i | (cnt_q == ratio_i - 1'b1));
  assign fall_o  = run_i & (bypass_i | (cnt_q == high_i - 1'b1));
  assign cnt_nxt = wrap_o ? '0 : cnt_q + 1'b1;
  // ratio of one: kernel clock passes straight through
  assign lvl_o   = bypass_i ? clk_i : lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      lvl_q <= (cnt_nxt < high_i);
    end
  end

  a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !bypass_i |-> cnt_q < ratio_i);

  a_r1_rise_after_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) && !bypass_i && $rose(lvl_q) |-> $past(wrap_o));
endmodule

// File: rtl/acg_bit_gen.sv
module acg_bit_gen #(
  parameter int unsigned M_W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         mck_i,
  input  logic [M_W:0] ratio_i,
  input  logic         pre_lvl_i,
  input  logic         pre_wrap_i,
  input  logic         pre_fall_i,
  output logic         mclk_o,
  output logic         bclk_o,
  output logic         bit_end_o
);
  logic [M_W:0] m_q, m_nxt, half_r;
  logic         bclk_q;

  assign half_r    = ratio_i >> 1;
  assign m_nxt     = (m_q == ratio_i - 1'b1) ? '0 : m_q + 1'b1;
  assign bit_end_o = mck_i ? (pre_wrap_i && (m_q == half_r - 1'b1)) : pre_fall_i;
  assign mclk_o    = mck_i & pre_lvl_i;
  assign bclk_o    = mck_i ? bclk_q : pre_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q    <= '0;
      bclk_q <= 1'b1;
    end else if (!run_i) begin
      m_q    <= '0;
      bclk_q <= 1'b1;
    end else if (pre_wrap_i) begin
      m_q    <= m_nxt;
      bclk_q <= (m_nxt < half_r);
    end
  end

  a_r9_fall_has_bit_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mck_i && run_i && $past(run_i) && $fell(bclk_q) |-> $past(bit_end_o));
endmodule

// File: rtl/acg_frame_gen.sv
module acg_frame_gen #(
  parameter int unsigned B_W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         bit_end_i,
  input  logic [B_W:0] half_i,
  output logic         ws_o,
  output logic         stb_o
);
  logic [B_W:0] b_q;
  logic         ws_q, stb_q;
  logic         last_bit;

  assign last_bit = (b_q == half_i - 1'b1);
  assign ws_o     = ws_q;
  assign stb_o    = stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_q   <= '0;
      ws_q  <= 1'b0;
      stb_q <= 1'b0;
    end else if (!run_i) begin
      b_q   <= '0;
      ws_q  <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= bit_end_i;
      if (bit_end_i) begin
        b_q <= last_bit ? '0 : b_q + 1'b1;
        if (last_bit) ws_q <= ~ws_q;
      end
    end
  end

  a_r8_ws_moves_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) && !$stable(ws_q) |-> stb_q);
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int unsigned DIV_W      = acg_pkg::DIV_W_DEF,
  parameter int unsigned MCK_FS_STD = acg_pkg::MCK_FS_STD_DEF,
  parameter int unsigned MCK_FS_DSP = acg_pkg::MCK_FS_DSP_DEF,
  parameter int unsigned FRAME_STD  = acg_pkg::FRAME_STD_DEF,
  parameter int unsigned FRAME_DSP  = acg_pkg::FRAME_DSP_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             odd_i,
  input  logic             mck_en_i,
  input  logic             dsp_i,
  input  logic             wide_i,
  output logic             mclk_o,
  output logic             bclk_o,
  output logic             ws_o,
  output logic             err_o,
  output logic             bclk_stb_o
);
  localparam int unsigned RATIO_STD = MCK_FS_STD / FRAME_STD;
  localparam int unsigned RATIO_DSP = MCK_FS_DSP / FRAME_DSP;
  localparam int unsigned RATIO_MAX = acg_pkg::max2(RATIO_STD, RATIO_DSP);
  localparam int unsigned M_W       = $clog2(RATIO_MAX);
  localparam int unsigned HALF_MAX  = acg_pkg::max2(FRAME_STD, FRAME_DSP);
  localparam int unsigned B_W       = $clog2(HALF_MAX);
  localparam logic [M_W:0] RAT_S  = (M_W+1)'(RATIO_STD);
  localparam logic [M_W:0] RAT_D  = (M_W+1)'(RATIO_DSP);
  localparam logic [B_W:0] HALF_S = (B_W+1)'(FRAME_STD / 2);
  localparam logic [B_W:0] HALF_D = (B_W+1)'(FRAME_DSP / 2);

  logic [DIV_W-1:0] div_q;
  logic             odd_q, mck_q, dsp_q, wide_q, run_q, err_q;
  logic             illegal_in;

  assign illegal_in = (div_i == DIV_W'(1)) && odd_i;

  // settings are captured only while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      odd_q  <= 1'b0;
      mck_q  <= 1'b0;
      dsp_q  <= 1'b0;
      wide_q <= 1'b0;
      run_q  <= 1'b0;
      err_q  <= 1'b0;
    end else if (!run_q) begin
      div_q  <= div_i;
      odd_q  <= odd_i;
      mck_q  <= mck_en_i;
      dsp_q  <= dsp_i;
      wide_q <= wide_i;
      err_q  <= illegal_in;
      run_q  <= en_i & ~illegal_in;
    end else begin
      run_q  <= en_i;
    end
  end

  logic [DIV_W:0] ratio, high;
  logic           bypass;
  logic [M_W:0]   m_ratio;
  logic [B_W:0]   half_bits;

  assign ratio     = {div_q, 1'b0} + {{DIV_W{1'b0}}, odd_q};
  assign high      = {1'b0, div_q} + {{DIV_W{1'b0}}, odd_q};
  assign bypass    = (div_q == '0);
  assign m_ratio   = (dsp_q ? RAT_D : RAT_S) >> wide_q;
  assign half_bits = (dsp_q ? HALF_D : HALF_S) << wide_q;

  logic pre_lvl, pre_wrap, pre_fall;
  logic mclk_w, bclk_w, bit_end, ws_w, stb_w;

  acg_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i, .rst_ni, .run_i(run_q), .bypass_i(bypass),
    .ratio_i(ratio), .high_i(high),
    .lvl_o(pre_lvl), .wrap_o(pre_wrap), .fall_o(pre_fall)
  );

  acg_bit_gen #(.M_W(M_W)) u_bit (
    .clk_i, .rst_ni, .run_i(run_q), .mck_i(mck_q), .ratio_i(m_ratio),
    .pre_lvl_i(pre_lvl), .pre_wrap_i(pre_wrap), .pre_fall_i(pre_fall),
    .mclk_o(mclk_w), .bclk_o(bclk_w), .bit_end_o(bit_end)
  );

  acg_frame_gen #(.B_W(B_W)) u_frm (
    .clk_i, .rst_ni, .run_i(run_q), .bit_end_i(bit_end), .half_i(half_bits),
    .ws_o(ws_w), .stb_o(stb_w)
  );

  assign mclk_o     = run_q & mclk_w;
  assign bclk_o     = run_q & bclk_w;
  assign ws_o       = run_q & ws_w;
  assign bclk_stb_o = run_q & stb_w;
  assign err_o      = err_q;

  a_r3_err_blocks_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !run_q);

  a_r10_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && $past(run_q) |-> $stable({div_q, odd_q, mck_q, dsp_q, wide_q}));
endmodule

// File: tb/audio_clkgen_tb_top.sv
module audio_clkgen_tb_top;
  logic       clk = 1'b0, rst_ni = 1'b0, en = 1'b0;
  logic [7:0] div = '0;
  logic       odd = 1'b0, mck = 1'b0, dsp = 1'b0, wide = 1'b0;
  logic       mclk_o, bclk_o, ws_o, err_o, bclk_stb_o;

  int checks = 0, fails = 0;
  int c_div, c_odd, c_mck, c_dsp, c_wide;

  always #4 clk = ~clk;

  audio_clkgen dut_i (
    .clk_i(clk), .rst_ni, .en_i(en), .div_i(div), .odd_i(odd),
    .mck_en_i(mck), .dsp_i(dsp), .wide_i(wide),
    .mclk_o, .bclk_o, .ws_o, .err_o, .bclk_stb_o
  );

  task automatic check(string tag, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // closed-form waveforms from the requirements; k = cycles since enable
  function automatic void expect_at(int k, output int eb, output int em,
                                    output int ews, output int est);
    int r, hi, rb, hb, m, half, t;
    r  = 2 * c_div + c_odd;
    hi = c_div + c_odd;
    if (c_div == 0) r = 1;
    half = ((c_dsp != 0 ? 16 : 32) << c_wide) / 2;
    if (c_mck != 0) begin
      m  = 8 >> c_wide;
      rb = m * r;
      hb = (m / 2) * r;
      em = ((k % r) < hi) ? 1 : 0;
    end else begin
      rb = r;
      hb = (c_div == 0) ? 1 : hi;
      em = 0;
    end
    eb  = ((k % rb) < hb) ? 1 : 0;
    est = (k >= hb && ((k - hb) % rb) == 0) ? 1 : 0;
    t   = (k >= hb) ? (k - hb) / rb + 1 : 0;
    ews = (t / half) % 2;
  endfunction

  task automatic run_cfg(string tag, int d, int o, int m, int ds, int w,
                         int n, bit scramble);
    int eb, em, ews, est;
    int kb = -1, km = -1, kw = -1, ks = -1;
    int ab = 0, xb = 0, am = 0, xm = 0, aw = 0, xw = 0, as_ = 0, xs = 0;
    bit byp;
    @(negedge clk);
    div = 8'(d); odd = o[0]; mck = m[0]; dsp = ds[0]; wide = w[0]; en = 1'b1;
    c_div = d; c_odd = o; c_mck = m; c_dsp = ds; c_wide = w;
    byp = (d == 0);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      expect_at(k, eb, em, ews, est);
      if (!(byp && m == 0) && kb < 0 && int'(bclk_o) != eb) begin kb = k; ab = int'(bclk_o); xb = eb; end
      if (!(byp && m != 0) && km < 0 && int'(mclk_o) != em) begin km = k; am = int'(mclk_o); xm = em; end
      if (kw < 0 && int'(ws_o) != ews) begin kw = k; aw = int'(ws_o); xw = ews; end
      if (ks < 0 && int'(bclk_stb_o) != est) begin ks = k; as_ = int'(bclk_stb_o); xs = est; end
      if (scramble && k == n / 2) begin
        div = 8'($urandom); odd = 1'($urandom); mck = 1'($urandom);
        dsp = 1'($urandom); wide = 1'($urandom);
      end
    end
    en = 1'b0;
    check($sformatf("%s/R1 bclk first bad cycle %0d", tag, kb), kb < 0, ab, xb);
    check($sformatf("%s/%s mclk first bad cycle %0d", tag, (m != 0) ? "R5" : "R6", km), km < 0, am, xm);
    check($sformatf("%s/R8 ws first bad cycle %0d", tag, kw), kw < 0, aw, xw);
    check($sformatf("%s/R9 strobe first bad cycle %0d", tag, ks), ks < 0, as_, xs);
    @(negedge clk);
    @(negedge clk);
    check({tag, "/R7 idle after disable"},
          {mclk_o, bclk_o, ws_o, bclk_stb_o} == 4'b0,
          int'({mclk_o, bclk_o, ws_o, bclk_stb_o}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int rd, ro;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R7 reset outputs", {mclk_o, bclk_o, ws_o, bclk_stb_o, err_o} == 5'b0,
          int'({mclk_o, bclk_o, ws_o, bclk_stb_o, err_o}), 0);

    run_cfg("R1 even", 3, 0, 0, 0, 0, 900, 1'b0);
    run_cfg("R1 odd", 2, 1, 0, 1, 0, 900, 1'b0);
    run_cfg("R6 wide", 1, 0, 0, 0, 1, 600, 1'b0);
    run_cfg("R2 max", 255, 1, 0, 0, 0, 1100, 1'b0);
    run_cfg("R5 std", 2, 1, 1, 0, 0, 1200, 1'b0);
    run_cfg("R5 dsp wide", 1, 1 - 1, 1, 1, 1, 700, 1'b0);
    run_cfg("R4 bypass", 0, 0, 0, 1, 0, 200, 1'b0);
    run_cfg("R4 bypass mck", 0, 1, 1, 0, 1, 300, 1'b0);

    // pass-through level in both clock phases
    @(negedge clk);
    div = 8'd0; odd = 1'b0; mck = 1'b0; en = 1'b1;
    repeat (3) @(negedge clk);
    @(posedge clk); #2;
    check("R4 bclk high with clk high", bclk_o === 1'b1, int'(bclk_o), 1);
    @(negedge clk); #1;
    check("R4 bclk low with clk low", bclk_o === 1'b0, int'(bclk_o), 0);
    en = 1'b0;
    repeat (2) @(negedge clk);

    // illegal divider
    div = 8'd1; odd = 1'b1; en = 1'b1;
    @(negedge clk);
    check("R3 err flagged", err_o === 1'b1, int'(err_o), 1);
    repeat (4) @(negedge clk);
    check("R3 outputs held low", {mclk_o, bclk_o, ws_o, bclk_stb_o} == 4'b0,
          int'({mclk_o, bclk_o, ws_o, bclk_stb_o}), 0);
    en = 1'b0; odd = 1'b0;
    @(negedge clk);
    check("R3 err cleared by legal value", err_o === 1'b0, int'(err_o), 0);

    // random legal settings with mid-run scrambling of the inputs
    for (int i = 0; i < 8; i++) begin
      rd = $urandom_range(0, 10);
      ro = $urandom_range(0, 1);
      if (rd == 1) ro = 0;
      run_cfg("R10 random", rd, ro, $urandom_range(0, 1), $urandom_range(0, 1),
              $urandom_range(0, 1), 1000, 1'b1);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule